// File: doc/BRIEF.md
# Parallel Flash Bus Interface Decoder

This block is the device-side front end of a parallel NOR-style flash memory. It samples the chip-select, output-gate, write-strobe, hardware-reset and width-select pins on a system clock. From them it picks one of five operating modes: read, write, output off, standby or hardware reset. It also steers a sixteen-line data bus between a full-word layout and a byte layout. In the byte layout the top data line becomes the lowest address bit and selects one half of the addressed word.

Behind the pins there are three pieces. The first is a small register-model array. The second is an identifier register that holds a fixed maker code and part code. The third is a command unit with three commands: enter identifier mode, return to array read, and a one-word program. A program takes a fixed number of clock cycles, and a busy flag is high while it runs. A long enough hardware-reset pulse aborts any program in progress, blocks the bus and returns the block to array read. Deselecting the chip does not stop a program.

Top module: `flash_bus_front`

## Requirements
- R1: With select low, output gate low, write strobe high and width select 1, all sixteen lines drive (`dq_oe` = 0xFFFF) and `dq_out` equals the addressed array word.
- R2: With width select 0, only lines 7..0 drive (`dq_oe` = 0x00FF). `dq_in[15]` picks the byte: 0 gives the word's bits 7..0 and 1 gives bits 15..8, placed on `dq_out[7:0]`. Lines 15..8 never drive in this layout.
- R3: `dq_oe` is 0 whenever the select is high (standby), whatever the output gate is. With the select low, `dq_oe` is 0 when the output gate is high or the write strobe is low.
- R4: After system reset the mode is array read, `busy` is 0, and word i of the array holds high byte (i XOR 0xA5) and low byte i.
- R5: A write is captured while select and write strobe are low and the output gate is high. It takes effect on the clock that first samples the write strobe high again. The command code is `dq_in[7:0]`: 0x90 enters identifier mode, 0xF0 returns to array read, 0xA0 arms a program, and any other code changes nothing.
- R6: In identifier mode a read returns the maker code (`MFR_CODE`) when address bit 0 is 0 and the part code (`DEV_CODE`) when it is 1. The code appears on lines 7..0 and lines 15..8 read 0 in the word layout.
- R7: The write that follows 0xA0 is program data. `busy` is high for exactly `PROG_CYCLES` clocks, starting at the commit edge, and then the array holds the new data. In the word layout all of `dq_in` is written. In the byte layout `dq_in[7:0]` goes to the half chosen by `dq_in[15]`.
- R8: Writes made while `busy` is high have no effect.
- R9: Raising the select while `busy` is high does not abort the program. `busy` stays high for its full length and the data is stored.
- R10: Once `hw_rst_n` has been sampled low on `RST_MIN` consecutive clocks, `dq_oe` is 0 and writes are ignored until `hw_rst_n` is sampled high. One clock later `busy` is 0, the running program is dropped with the array unchanged, and the mode is array read.
- R11: A `hw_rst_n` pulse lasting fewer than `RST_MIN` clocks has no effect on mode, program or reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output gate, active low |
| we_n | input | 1 | Write strobe, active low |
| hw_rst_n | input | 1 | Hardware reset pin, active low, filtered |
| word_sel | input | 1 | 1 selects the word layout, 0 the byte layout |
| addr | input | ADDR_W | Word address |
| dq_in | input | 16 | Data lines as seen at the pins (bit 15 is the byte address in the byte layout) |
| dq_out | output | 16 | Data driven onto the lines |
| dq_oe | output | 16 | Per-line drive enable |
| busy | output | 1 | High while a program runs |

## Verification
Read data and `dq_oe` come from combinational logic on the pins, the mode and the array. The bench therefore checks them a short delay after it drives the pins at a falling clock edge. A command takes effect on the rising edge that samples the write strobe high, so its results are checked at the next falling edge. `busy` rises at that same commit edge and is counted at each following falling edge until it drops, and the count must equal `PROG_CYCLES`. The reset effects on the bus are checked at the falling edge after the `RST_MIN`-th low sample. The cleared `busy` is checked one edge after that.

// File: rtl/flash_pkg.sv
// Shared types and command codes for the flash bus front end.
// Assumes a sixteen-line data bus; command codes are decoded from bits 7..0.
package flash_pkg;
    localparam int DQ_W = 16;

    typedef enum logic [1:0] {
        MODE_READ   = 2'd0,
        MODE_ID     = 2'd1,
        MODE_PSETUP = 2'd2
    } flash_mode_e;

    localparam logic [7:0] CMD_ID_ENTER = 8'h90;
    localparam logic [7:0] CMD_TO_READ  = 8'hF0;
    localparam logic [7:0] CMD_PROGRAM  = 8'hA0;
endpackage

// File: rtl/flash_rst_filter.sv
// Hardware reset pulse filter: asserts rst_active once hw_rst_n has been
// sampled low on RST_MIN consecutive clocks; clears on the first high sample.
// Assumes hw_rst_n is already synchronous to clk.
module flash_rst_filter #(
    parameter int RST_MIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_rst_n,
    output logic rst_active
);
    localparam int CW = $clog2(RST_MIN + 1);

    logic [CW-1:0] low_cnt;

    // Count consecutive low samples, saturating at RST_MIN.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (hw_rst_n) begin
            low_cnt <= '0;
        end else if (low_cnt != CW'(RST_MIN)) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    assign rst_active = (low_cnt == CW'(RST_MIN));
endmodule

// File: rtl/flash_cmd_ctrl.sv
// Command unit: captures bus writes, commits them on the rising write strobe,
// tracks the internal mode and times a program with a down-counter.
// Assumes pins are synchronous to clk; abort comes from the reset filter.
module flash_cmd_ctrl
    import flash_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int PROG_CYCLES = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              word_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DQ_W-1:0]   dq_in,
    output flash_mode_e       mode,
    output logic              busy,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DQ_W-1:0]   wr_data,
    output logic [1:0]        wr_mask
);
    localparam int TW = $clog2(PROG_CYCLES + 1);

    logic              we_q;
    logic              armed;
    logic [ADDR_W-1:0] cap_addr;
    logic [DQ_W-1:0]   cap_data;
    logic              cap_word;
    logic [TW-1:0]     timer;
    logic              bus_wr;
    logic              commit;

    assign bus_wr = !ce_n && oe_n && !we_n && !abort;
    assign commit = armed && we_n && !we_q && !abort;

    // Capture, commit, mode tracking and program timing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q     <= 1'b1;
            armed    <= 1'b0;
            cap_addr <= '0;
            cap_data <= '0;
            cap_word <= 1'b1;
            mode     <= MODE_READ;
            busy     <= 1'b0;
            timer    <= '0;
            wr_addr  <= '0;
            wr_data  <= '0;
            wr_mask  <= '0;
        end else begin
            we_q <= we_n;
            if (abort) begin
                armed <= 1'b0;
                busy  <= 1'b0;
                timer <= '0;
                mode  <= MODE_READ;
            end else begin
                if (bus_wr && !busy) begin
                    armed    <= 1'b1;
                    cap_addr <= addr;
                    cap_data <= dq_in;
                    cap_word <= word_sel;
                end else if (commit || ce_n || !oe_n) begin
                    armed <= 1'b0;
                end

                if (commit) begin
                    if (mode == MODE_PSETUP) begin
                        busy    <= 1'b1;
                        timer   <= TW'(PROG_CYCLES - 1);
                        wr_addr <= cap_addr;
                        mode    <= MODE_READ;
                        if (cap_word) begin
                            wr_data <= cap_data;
                            wr_mask <= 2'b11;
                        end else begin
                            wr_data <= {cap_data[7:0], cap_data[7:0]};
                            wr_mask <= cap_data[15] ? 2'b10 : 2'b01;
                        end
                    end else begin
                        case (cap_data[7:0])
                            CMD_ID_ENTER: mode <= MODE_ID;
                            CMD_TO_READ:  mode <= MODE_READ;
                            CMD_PROGRAM:  mode <= MODE_PSETUP;
                            default:      mode <= mode;
                        endcase
                    end
                end

                if (busy) begin
                    if (timer == '0) begin
                        busy <= 1'b0;
                    end else begin
                        timer <= timer - 1'b1;
                    end
                end
            end
        end
    end

    assign wr_en = busy && (timer == '0) && !abort;
endmodule

// File: rtl/flash_array.sv
// Register model of the word array with per-byte write enables.
// Assumes a small depth; reset loads a computed pattern into every word.
module flash_array
    import flash_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DQ_W-1:0]   wr_data,
    input  logic [1:0]        wr_mask,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DQ_W-1:0]   rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DQ_W-1:0] mem [DEPTH];

    // Load the pattern on reset, otherwise apply masked byte writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= {8'(i) ^ 8'hA5, 8'(i)};
            end
        end else if (wr_en) begin
            if (wr_mask[0]) mem[wr_addr][7:0]  <= wr_data[7:0];
            if (wr_mask[1]) mem[wr_addr][15:8] <= wr_data[15:8];
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/flash_io_steer.sv
// Output steering: picks array or identifier data, selects the byte lane in
// the byte layout and computes the per-line drive enables.
// Assumes dq_in[15] is the byte address when the byte layout is selected.
module flash_io_steer
    import flash_pkg::*;
#(
    parameter logic [7:0] MFR_CODE = 8'h37,
    parameter logic [7:0] DEV_CODE = 8'hC4
) (
    input  flash_mode_e     mode,
    input  logic [DQ_W-1:0] rd_word,
    input  logic            addr_lsb,
    input  logic            byte_hi,
    input  logic            word_sel,
    input  logic            ce_n,
    input  logic            oe_n,
    input  logic            we_n,
    input  logic            rst_active,
    output logic [DQ_W-1:0] dq_out,
    output logic [DQ_W-1:0] dq_oe
);
    logic            drive;
    logic [DQ_W-1:0] src;

    assign drive = !ce_n && !oe_n && we_n && !rst_active;

    // Select the data source and lay it onto the bus for the width in use.
    always_comb begin
        if (mode == MODE_ID) begin
            src = {8'h00, addr_lsb ? DEV_CODE : MFR_CODE};
        end else if (word_sel) begin
            src = rd_word;
        end else begin
            src = {8'h00, byte_hi ? rd_word[15:8] : rd_word[7:0]};
        end
        dq_out = drive ? src : '0;
        dq_oe  = drive ? (word_sel ? 16'hFFFF : 16'h00FF) : '0;
    end
endmodule

// File: rtl/flash_bus_front.sv
// Top of the flash bus front end: reset filter, command unit, array model
// and output steering. Pins are sampled on clk; outputs are combinational.
module flash_bus_front
    import flash_pkg::*;
#(
    parameter int         ADDR_W      = 4,
    parameter int         PROG_CYCLES = 20,
    parameter int         RST_MIN     = 4,
    parameter logic [7:0] MFR_CODE    = 8'h37,
    parameter logic [7:0] DEV_CODE    = 8'hC4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              hw_rst_n,
    input  logic              word_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       dq_in,
    output logic [15:0]       dq_out,
    output logic [15:0]       dq_oe,
    output logic              busy
);
    logic              rst_active;
    flash_mode_e       mode;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DQ_W-1:0]   wr_data;
    logic [1:0]        wr_mask;
    logic [DQ_W-1:0]   rd_word;

    flash_rst_filter #(.RST_MIN(RST_MIN)) rst_filt_i (
        .clk(clk), .rst_n(rst_n), .hw_rst_n(hw_rst_n), .rst_active(rst_active)
    );

    flash_cmd_ctrl #(.ADDR_W(ADDR_W), .PROG_CYCLES(PROG_CYCLES)) cmd_i (
        .clk(clk), .rst_n(rst_n), .abort(rst_active),
        .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .word_sel(word_sel),
        .addr(addr), .dq_in(dq_in), .mode(mode), .busy(busy),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_mask(wr_mask)
    );

    flash_array #(.ADDR_W(ADDR_W)) array_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_mask(wr_mask), .rd_addr(addr), .rd_data(rd_word)
    );

    flash_io_steer #(.MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) steer_i (
        .mode(mode), .rd_word(rd_word), .addr_lsb(addr[0]), .byte_hi(dq_in[15]),
        .word_sel(word_sel), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .rst_active(rst_active), .dq_out(dq_out), .dq_oe(dq_oe)
    );
endmodule

// File: rtl/flash_bus_front_chk.sv
// Checker for flash_bus_front: pin-level drive rules, reset abort and
// program start timing. Attached to the top by the bind below.
module flash_bus_front_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        ce_n,
    input logic        we_n,
    input logic        word_sel,
    input logic [15:0] dq_oe,
    input logic        busy,
    input logic        rst_active
);
    // R3
    standby_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> dq_oe == 16'h0000);

    // R2
    byte_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !word_sel |-> dq_oe[15:8] == 8'h00);

    // R10
    rst_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_active |-> dq_oe == 16'h0000);

    // R10
    rst_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_active |=> !busy);

    // R7
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(we_n) && !$past(we_n, 2)));
endmodule

bind flash_bus_front flash_bus_front_chk chk_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .word_sel(word_sel),
    .dq_oe(dq_oe), .busy(busy), .rst_active(rst_active)
);

// File: tb/flash_bus_front_tb_top.sv
// Self-checking bench: sweeps pin combinations and addresses, then runs the
// command, program and reset scenarios against a bench-side array model.
module flash_bus_front_tb_top;
    localparam int         ADDR_W = 4;
    localparam int         PROG   = 20;
    localparam int         RMIN   = 4;
    localparam logic [7:0] MFR    = 8'h37;
    localparam logic [7:0] DEV    = 8'hC4;
    localparam int         DEPTH  = 1 << ADDR_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, hw_rst_n = 1'b1, word_sel = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [15:0] dq_in = '0;
    logic [15:0] dq_out, dq_oe;
    logic busy;

    int checks = 0;
    int fails = 0;
    logic [15:0] exp_mem [DEPTH];

    always #2 clk = ~clk;

    flash_bus_front #(.ADDR_W(ADDR_W), .PROG_CYCLES(PROG), .RST_MIN(RMIN),
                      .MFR_CODE(MFR), .DEV_CODE(DEV)) dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .hw_rst_n(hw_rst_n), .word_sel(word_sel), .addr(addr), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe), .busy(busy)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [15:0] d, input logic w);
        @(negedge clk);
        word_sel = w; addr = a; dq_in = d; ce_n = 0; oe_n = 1; we_n = 0;
        @(negedge clk);
        we_n = 1;
        @(negedge clk);
        ce_n = 1; dq_in = '0;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, input logic w, input logic hi);
        @(negedge clk);
        word_sel = w; addr = a; dq_in = {hi, 15'h0}; ce_n = 0; oe_n = 0; we_n = 1;
        #1;
    endtask

    task automatic read_array(input string req, input logic [ADDR_W-1:0] a);
        bus_read(a, 1'b1, 1'b0);
        check(req, dq_oe, 16'hFFFF);
        check(req, dq_out, exp_mem[a]);
        ce_n = 1;
    endtask

    function automatic int busy_len_start();
        return 0;
    endfunction

    initial begin
        #(200000 * 4);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int n;
        for (int i = 0; i < DEPTH; i++) exp_mem[i] = {8'(i) ^ 8'hA5, 8'(i)};
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        #1;
        // R4 reset state
        check("R4 busy", {15'h0, busy}, 16'h0);
        check("R4 idle oe", dq_oe, 16'h0);
        read_array("R4 pattern", 4'd7);

        // R1 R2 R3 sweep over pin combinations, addresses and byte select
        for (int c = 0; c < 16; c++) begin
            for (int a = 0; a < DEPTH; a++) begin
                for (int h = 0; h < 2; h++) begin
                    logic drv;
                    logic [15:0] eo, ed;
                    @(negedge clk);
                    ce_n = c[0]; oe_n = c[1]; we_n = c[2]; word_sel = c[3];
                    addr = ADDR_W'(a); dq_in = {h[0], 15'h0};
                    #1;
                    drv = !c[0] && !c[1] && c[2];
                    eo = drv ? (c[3] ? 16'hFFFF : 16'h00FF) : 16'h0;
                    ed = c[3] ? exp_mem[a] : {8'h00, h[0] ? exp_mem[a][15:8] : exp_mem[a][7:0]};
                    check(c[0] ? "R3 standby" : (c[3] ? "R1 oe" : "R2 oe"), dq_oe, eo);
                    if (drv) check(c[3] ? "R1 data" : "R2 data", dq_out & eo, ed);
                end
            end
        end
        @(negedge clk);
        ce_n = 1; oe_n = 1; we_n = 1; word_sel = 1; dq_in = '0;

        // R5 R6 identifier mode
        bus_write(4'd0, 16'h0090, 1'b1);
        bus_read(4'd0, 1'b1, 1'b0); check("R6 maker", dq_out, {8'h00, MFR});
        bus_read(4'd1, 1'b1, 1'b0); check("R6 part", dq_out, {8'h00, DEV});
        bus_read(4'd2, 1'b1, 1'b0); check("R6 offset", dq_out, {8'h00, MFR});
        bus_read(4'd3, 1'b0, 1'b1); check("R6 byte", dq_out, {8'h00, DEV});
        check("R6 byte oe", dq_oe, 16'h00FF);
        ce_n = 1;
        bus_write(4'd0, 16'h0055, 1'b1);
        bus_read(4'd1, 1'b1, 1'b0); check("R5 unknown code", dq_out, {8'h00, DEV});
        ce_n = 1;
        bus_write(4'd0, 16'h00F0, 1'b1);
        read_array("R6 back to read", 4'd1);

        // R7 R9 word program, busy length counted with select high
        bus_write(4'd0, 16'h00A0, 1'b1);
        bus_write(4'd5, 16'hBEEF, 1'b1);
        n = 0;
        #1;
        while (busy && n < 200) begin
            n++;
            @(negedge clk);
            #1;
        end
        check("R7 R9 busy length", 16'(n), 16'(PROG));
        exp_mem[5] = 16'hBEEF;
        read_array("R7 word program", 4'd5);

        // R7 byte program into the high half
        bus_write(4'd0, 16'h00A0, 1'b0);
        bus_write(4'd3, 16'h803C, 1'b0);
        wait (!busy);
        exp_mem[3][15:8] = 8'h3C;
        read_array("R7 byte program", 4'd3);

        // R8 write during busy is ignored
        bus_write(4'd0, 16'h00A0, 1'b1);
        bus_write(4'd9, 16'h1234, 1'b1);
        bus_write(4'd0, 16'h0090, 1'b1);
        check("R8 still busy", {15'h0, busy}, 16'h1);
        wait (!busy);
        exp_mem[9] = 16'h1234;
        read_array("R8 write ignored", 4'd9);

        // R10 long reset aborts program and blocks the bus
        bus_write(4'd0, 16'h00A0, 1'b1);
        bus_write(4'd6, 16'h0F0F, 1'b1);
        @(negedge clk);
        hw_rst_n = 0;
        repeat (RMIN) @(negedge clk);
        ce_n = 0; oe_n = 0; we_n = 1; word_sel = 1; addr = 4'd6;
        #1;
        check("R10 bus off", dq_oe, 16'h0);
        @(negedge clk);
        #1;
        check("R10 busy cleared", {15'h0, busy}, 16'h0);
        ce_n = 1;
        bus_write(4'd0, 16'h0090, 1'b1);
        hw_rst_n = 1;
        @(negedge clk);
        repeat (PROG) @(negedge clk);
        read_array("R10 abort and mode", 4'd6);

        // R11 short reset pulse is ignored
        bus_write(4'd0, 16'h0090, 1'b1);
        @(negedge clk);
        hw_rst_n = 0;
        repeat (RMIN - 1) @(negedge clk);
        hw_rst_n = 1;
        bus_read(4'd1, 1'b1, 1'b0); check("R11 mode kept", dq_out, {8'h00, DEV});
        ce_n = 1;
        bus_write(4'd0, 16'h00F0, 1'b1);
        bus_write(4'd0, 16'h00A0, 1'b1);
        bus_write(4'd11, 16'h7777, 1'b1);
        @(negedge clk);
        hw_rst_n = 0;
        repeat (RMIN - 1) @(negedge clk);
        hw_rst_n = 1;
        #1;
        check("R11 program kept", {15'h0, busy}, 16'h1);
        wait (!busy);
        exp_mem[11] = 16'h7777;
        read_array("R11 program done", 4'd11);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule